// File: doc/BRIEF.md
# EDID DDC Read Engine

This block is a read-only two-wire bus master that fetches one block of display identification data from a monitor. Software sets up a request with two register writes: first the target device address, then one data byte. The request is kept only when the target is the display's data address or its segment-pointer address. The byte then becomes either the word offset or the segment number. A write to the start register runs the whole bus sequence without further help. That sequence is an optional segment write, then the word-offset write, then a repeated START and a read of the full block.

Incoming bytes are stored in an internal buffer. Software drains that buffer through a single data register whose read pointer advances on every read. When the transfer ends, the block sets a sticky status bit: ready on success, or error if the device did not acknowledge. Writing a 1 to a status bit clears it. A mask register selects which status bits drive the interrupt line. The bus clock comes from a 16-bit divider, and one SCL period lasts four times the divider value in reference clocks.

Register map (reg_addr): 0 divider low byte, 1 divider high byte, 2 write: request target / read: segment, 3 write: request data / read: word offset, 4 bit 0 start (read: bit 0 busy), 5 status (bit 0 ready, bit 1 error, bit 2 invalid request; write 1 to clear), 6 interrupt mask (same bit positions), 7 buffer data, 8 buffer read pointer.

Top module: `edid_ddc_reader`

## Requirements
- R1: The SCL period is 4 x D reference clock cycles. D is the 16-bit divider, with register 0 as its low byte and register 1 as its high byte. D resets to DIV_INIT.
- R2: A write to register 3 first clears both the segment and the word offset. If the target last written to register 2 equals SEG_DEV, the data byte becomes the segment. If the target equals EDID_DEV, the data byte becomes the word offset. For any other target, status bit 2 is set and both values stay 0.
- R3: Writing 1 to bit 0 of register 4 while idle resets the buffer read pointer to 0 and starts a fetch. The same write while busy is ignored.
- R4: With segment 0, the bus carries: START, EDID_DEV, word offset, repeated START, EDID_DEV+1, BLOCK_LEN data bytes, STOP.
- R5: With a nonzero segment, the sequence begins START, SEG_DEV, segment, repeated START. The rest follows R4 from EDID_DEV onward.
- R6: The master acknowledges every received byte except the last one, which it does not acknowledge, and then sends STOP.
- R7: If an address or offset byte is not acknowledged, the master sends STOP and sets status bit 1 (error), and status bit 0 (ready) is not set.
- R8: A successful fetch sets status bit 0. The bit stays set until software writes a 1 to it.
- R9: irq is high exactly when some status bit is set and its mask bit in register 6 is set.
- R10: Reading register 7 returns the buffer byte at the read pointer and then increments the pointer. Register 8 reads and sets the pointer.
- R11: Both bus lines are released while idle. Inside a data or acknowledge bit, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances buffer pointer on register 7) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_i | input | 1 | Sampled SDA line level |
| irq | output | 1 | Masked status interrupt |
| busy | output | 1 | A fetch is in progress |

## Verification
The bench builds the block with BLOCK_LEN set to 8 and DIV_INIT set to 2. Each fetch then takes only a few hundred reference cycles, so that every byte of the block, the final not-acknowledged byte and several whole transfers fit within a short run. A behavioural display model on the bus logs the address bytes it sees and the master's acknowledge pattern. It can refuse a chosen address, which makes the error path reachable. Rewriting the divider to 3 checks that the measured SCL period follows the register value.

// File: rtl/edid_ddc_reader.sv
module edid_ddc_reader #(
  parameter int          BLOCK_LEN = 128,
  parameter logic [15:0] DIV_INIT  = 16'd63,
  parameter logic [7:0]  EDID_DEV  = 8'hA0,
  parameter logic [7:0]  SEG_DEV   = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i,
  output logic       irq,
  output logic       busy
);
  localparam int AW = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int CW = $clog2(BLOCK_LEN + 1);

  typedef enum logic [1:0] {K_IDLE, K_START, K_BIT, K_STOP} kind_t;
  typedef enum logic [2:0] {P_SEGA, P_SEGD, P_WA, P_WD, P_RA, P_RD} ph_t;

  logic [15:0]   div, dcnt;
  logic [7:0]    tgt, seg, word, sh;
  logic [2:0]    stat, msk;
  logic [AW-1:0] rptr;
  logic [CW-1:0] cnt;
  kind_t         kind;
  ph_t           ph;
  logic [3:0]    bitn;
  logic [1:0]    q;
  logic          nack, fail;
  logic [7:0]    mem [BLOCK_LEN];
  logic          scl_v, sda_v;

  wire tick      = (kind != K_IDLE) && (({1'b0, dcnt} + 17'd1) >= {1'b0, div});
  wire tx        = (ph != P_RD);
  wire last      = (cnt == CW'(BLOCK_LEN - 1));
  wire start_req = reg_wr && reg_addr == 4'd4 && reg_wdata[0] && kind == K_IDLE;
  wire fifo_rd   = reg_rd && reg_addr == 4'd7;
  wire fifo_we   = tick && kind == K_BIT && q == 2'd3 && bitn == 4'd8 && ph == P_RD;

  assign busy   = (kind != K_IDLE);
  assign irq    = |(stat & msk);
  assign scl_oe = !scl_v;
  assign sda_oe = !sda_v;

  always_comb begin
    scl_v = 1'b1;
    sda_v = 1'b1;
    case (kind)
      K_START: begin
        scl_v = (q == 2'd1 || q == 2'd2);
        sda_v = (q < 2'd2);
      end
      K_BIT: begin
        scl_v = (q == 2'd1 || q == 2'd2);
        if (bitn < 4'd8) sda_v = tx ? sh[7] : 1'b1;
        else             sda_v = tx ? 1'b1 : last;
      end
      K_STOP: begin
        scl_v = (q != 2'd0);
        sda_v = (q >= 2'd2);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = div[7:0];
      4'd1:    reg_rdata = div[15:8];
      4'd2:    reg_rdata = seg;
      4'd3:    reg_rdata = word;
      4'd4:    reg_rdata = {7'd0, busy};
      4'd5:    reg_rdata = {5'd0, stat};
      4'd6:    reg_rdata = {5'd0, msk};
      4'd7:    reg_rdata = mem[rptr];
      4'd8:    reg_rdata = 8'(rptr);
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) if (fifo_we) mem[cnt[AW-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= DIV_INIT; dcnt <= '0; tgt <= '0; seg <= '0; word <= '0; sh <= '0;
      stat <= '0; msk <= '0; rptr <= '0; cnt <= '0; kind <= K_IDLE; ph <= P_WA;
      bitn <= '0; q <= '0; nack <= 1'b0; fail <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          4'd0: div[7:0]  <= reg_wdata;
          4'd1: div[15:8] <= reg_wdata;
          4'd2: tgt <= reg_wdata;
          4'd3: begin
            seg  <= '0;
            word <= '0;
            if (tgt == SEG_DEV)       seg  <= reg_wdata;
            else if (tgt == EDID_DEV) word <= reg_wdata;
            else                      stat[2] <= 1'b1;
          end
          4'd5: stat <= stat & ~reg_wdata[2:0];
          4'd6: msk <= reg_wdata[2:0];
          4'd8: rptr <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      if (fifo_rd) rptr <= rptr + AW'(1);

      if (start_req) begin
        rptr <= '0; cnt <= '0; fail <= 1'b0; nack <= 1'b0;
        ph   <= (seg != 8'd0) ? P_SEGA : P_WA;
        kind <= K_START; q <= '0; dcnt <= '0;
      end else if (kind != K_IDLE) begin
        dcnt <= tick ? 16'd0 : dcnt + 16'd1;
        if (tick) begin
          q <= q + 2'd1;
          if (kind == K_BIT && q == 2'd2) begin
            if (bitn < 4'd8) begin
              if (!tx) sh <= {sh[6:0], sda_i};
            end else if (tx) nack <= sda_i;
          end
          if (q == 2'd3) begin
            case (kind)
              K_START: begin
                kind <= K_BIT;
                bitn <= '0;
                sh   <= (ph == P_SEGA) ? SEG_DEV : (ph == P_WA) ? EDID_DEV : (EDID_DEV | 8'h01);
              end
              K_BIT: begin
                if (bitn < 4'd8) begin
                  bitn <= bitn + 4'd1;
                  if (tx) sh <= {sh[6:0], 1'b0};
                end else begin
                  bitn <= '0;
                  if (tx && nack) begin
                    fail <= 1'b1;
                    kind <= K_STOP;
                  end else begin
                    case (ph)
                      P_SEGA: begin ph <= P_SEGD; sh <= seg; end
                      P_SEGD: begin ph <= P_WA; kind <= K_START; end
                      P_WA:   begin ph <= P_WD; sh <= word; end
                      P_WD:   begin ph <= P_RA; kind <= K_START; end
                      P_RA:   ph <= P_RD;
                      default: begin
                        cnt <= cnt + CW'(1);
                        if (last) kind <= K_STOP;
                      end
                    endcase
                  end
                end
              end
              K_STOP: begin
                kind <= K_IDLE;
                if (fail) stat[1] <= 1'b1;
                else      stat[0] <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_IDLE) |-> (!scl_oe && !sda_oe));

  p_sda_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BIT && $past(kind == K_BIT) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(stat[0]) && $rose(stat[1])));

  p_start_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (rptr == '0));

  p_rptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !start_req && !(reg_wr && reg_addr == 4'd8)) |=> (rptr == $past(rptr) + AW'(1)));

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BLOCK_LEN));
endmodule

// File: tb/sim_edid_ddc_reader.sv
module sim_edid_ddc_reader;
  localparam int CLK_NS = 10;
  localparam int BL     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq, busy;
  logic s_drv = 1'b0;
  wire  scl_line = !scl_oe;
  wire  sda_line = !(sda_oe || s_drv);

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  edid_ddc_reader #(.BLOCK_LEN(BL), .DIV_INIT(16'd2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_i(sda_line), .irq(irq), .busy(busy));

  // display model
  int bitc = 0, n_addr = 0, n_mack = 0, n_mnack = 0;
  logic [7:0] addr_log [8];
  logic [7:0] ssh = '0, curaddr = '0, rbyte = '0, sseg = '0, sptr = '0, nack_dev = '0;
  logic active = 1'b0, jst = 1'b0, in_addr = 1'b0, reading = 1'b0, mack = 1'b0;

  function automatic logic [7:0] romv(input logic [7:0] s, input logic [7:0] a);
    return 8'(a * 3 + s * 8'h5B);
  endfunction

  always @(negedge sda_line) if (scl_line) begin
    active = 1'b1; jst = 1'b1; bitc = 0; in_addr = 1'b1; reading = 1'b0; s_drv = 1'b0;
  end
  always @(posedge sda_line) if (scl_line && active) begin
    active = 1'b0; s_drv = 1'b0; sseg = '0;
  end
  always @(posedge scl_line) if (active) begin
    if (bitc < 8) ssh = {ssh[6:0], sda_line};
    else mack = !sda_line;
  end
  always @(negedge scl_line) if (active) begin
    if (jst) jst = 1'b0;
    else if (bitc < 8) begin
      bitc++;
      if (bitc == 8) begin
        if (in_addr) begin
          if (n_addr < 8) addr_log[n_addr] = ssh;
          n_addr++;
          curaddr = ssh;
          s_drv = (ssh == 8'hA0 || ssh == 8'hA1 || ssh == 8'h60) && ssh != nack_dev;
          reading = (ssh == 8'hA1) && s_drv;
        end else if (reading) s_drv = 1'b0;
        else begin
          if (curaddr == 8'h60) sseg = ssh;
          else if (curaddr == 8'hA0) sptr = ssh;
          s_drv = 1'b1;
        end
      end else if (reading && !in_addr) s_drv = !rbyte[7-bitc];
    end else begin
      bitc = 0; s_drv = 1'b0;
      if (reading && !in_addr) begin
        if (mack) n_mack++; else n_mnack++;
      end
      if (reading && (in_addr || mack)) begin
        rbyte = romv(sseg, sptr); sptr++; s_drv = !rbyte[7];
      end
      in_addr = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 20000; i++) begin
      rd(4'd5, st);
      if (st[1:0] != 2'b00) break;
    end
  endtask

  task automatic clear_log();
    n_addr = 0; n_mack = 0; n_mnack = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd0, v); chk("R1 reset divider low", v, 8'd2);
    rd(4'd5, v); chk("R8 reset status", v, 8'd0);
    chk("R11 idle lines", {scl_line, sda_line, irq}, 3'b110);
  endtask

  task automatic t_request();
    logic [7:0] v;
    wr(4'd2, 8'hA0); wr(4'd3, 8'h80);
    rd(4'd3, v); chk("R2 word offset", v, 8'h80);
    wr(4'd2, 8'h60); wr(4'd3, 8'h02);
    rd(4'd2, v); chk("R2 segment", v, 8'h02);
    rd(4'd3, v); chk("R2 word cleared", v, 8'h00);
    wr(4'd2, 8'h50); wr(4'd3, 8'h33);
    rd(4'd5, v); chk("R2 invalid flag", v, 8'h04);
    rd(4'd2, v); chk("R2 invalid seg cleared", v, 8'h00);
    wr(4'd5, 8'h04);
    rd(4'd5, v); chk("R8 invalid cleared", v, 8'h00);
  endtask

  task automatic t_plain();
    logic [7:0] v, st;
    realtime t1, t2;
    clear_log();
    wr(4'd2, 8'hA0); wr(4'd3, 8'h80);
    wr(4'd4, 8'h01);
    wr(4'd4, 8'h01);
    @(posedge scl_line); @(posedge scl_line); t1 = $realtime;
    @(posedge scl_line); t2 = $realtime;
    chk("R1 SCL period div2", 32'(int'((t2 - t1) / CLK_NS)), 32'd8);
    wait_done(st);
    chk("R8 ready set", st, 8'h01);
    chk("R9 irq masked off", irq, 1'b0);
    repeat (20) @(negedge clk);
    chk("R3 second start ignored", {busy, 32'(n_addr)}, {1'b0, 32'd2});
    chk("R4 address bytes", {addr_log[0], addr_log[1]}, 16'hA0A1);
    chk("R6 acks", 32'(n_mack), 32'(BL - 1));
    chk("R6 final nack", 32'(n_mnack), 32'd1);
    for (int i = 0; i < BL; i++) begin
      rd(4'd7, v); chk("R10 data byte", v, romv(8'd0, 8'(8'h80 + i)));
    end
    wr(4'd8, 8'd3);
    rd(4'd7, v); chk("R10 pointer set", v, romv(8'd0, 8'h83));
    rd(4'd8, v); chk("R10 pointer advanced", v, 8'd4);
    wr(4'd6, 8'h01); @(negedge clk);
    chk("R9 irq on ready", irq, 1'b1);
    wr(4'd5, 8'h01);
    rd(4'd5, v); chk("R8 ready write-one clear", v, 8'h00);
    chk("R9 irq after clear", irq, 1'b0);
  endtask

  task automatic t_segment();
    logic [7:0] v, st;
    clear_log();
    wr(4'd2, 8'h60); wr(4'd3, 8'h01);
    wr(4'd8, 8'd5);
    wr(4'd4, 8'h01);
    rd(4'd8, v); chk("R3 pointer reset at start", v, 8'd0);
    wait_done(st);
    chk("R5 ready", st, 8'h01);
    chk("R5 address bytes", {addr_log[0], addr_log[1], addr_log[2]}, 24'h60A0A1);
    rd(4'd7, v); chk("R5 first byte", v, romv(8'd1, 8'd0));
    rd(4'd7, v); chk("R5 second byte", v, romv(8'd1, 8'd1));
    wr(4'd5, 8'h07);
  endtask

  task automatic t_nack();
    logic [7:0] st;
    clear_log();
    nack_dev = 8'hA1;
    wr(4'd6, 8'h02);
    wr(4'd2, 8'hA0); wr(4'd3, 8'h00);
    wr(4'd4, 8'h01);
    wait_done(st);
    chk("R7 error only", st, 8'h02);
    chk("R7 no data bytes", 32'(n_mack + n_mnack), 32'd0);
    chk("R9 irq on error", irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 bus released", {busy, scl_line, sda_line}, 3'b011);
    wr(4'd5, 8'h02); wr(4'd6, 8'h00);
    nack_dev = 8'h00;
  endtask

  task automatic t_divider();
    logic [7:0] v, st;
    realtime t1, t2;
    wr(4'd0, 8'd3); wr(4'd1, 8'd0);
    rd(4'd0, v); chk("R1 divider readback", v, 8'd3);
    wr(4'd2, 8'hA0); wr(4'd3, 8'h00);
    wr(4'd4, 8'h01);
    @(posedge scl_line); @(posedge scl_line); t1 = $realtime;
    @(posedge scl_line); t2 = $realtime;
    chk("R1 SCL period div3", 32'(int'((t2 - t1) / CLK_NS)), 32'd12);
    wait_done(st);
    chk("R4 fetch at div3", st, 8'h01);
    rd(4'd7, v); chk("R4 data at div3", v, romv(8'd0, 8'd0));
    wr(4'd5, 8'h07);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_request();
    t_plain();
    t_segment();
    t_nack();
    t_divider();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule